// File: doc/BRIEF.md
# Dual-Insert Top-K Correlation Sorter

This block ranks cross-correlation magnitudes for one received symbol. Two correlator banks run side by side. On every accepted step the sorter takes one magnitude from each bank, and each magnitude carries the pattern or shift index that produced it. Both values are merged into a buffer of `DEPTH` ranked slots. Slot 0 always holds the largest magnitude seen since the last clear, and the last slot holds the smallest magnitude that is still kept. A value that is too small to displace any stored entry is dropped.

A symbol goes through these steps:
1. A clear empties the buffer.
2. A start pulse from the metric stage says that its correlations are ready.
3. `NUM_PAIRS` valid pairs are streamed in.
4. The sorter raises `done_o` for one cycle.
5. The ranked magnitudes and indices are then held for the downstream candidate searcher until the next clear.

The merge is a single-cycle network. Each step costs one clock, so one symbol takes `NUM_PAIRS` cycles after the start pulse.

Top module: `corr_topk_sorter`

## Requirements
- R1: While `clr_i` is high, the next clock edge sets every slot to magnitude 0 and index 0, returns the control to idle, and keeps `done_o` low. Clear takes priority over every other input.
- R2: `start_i` is acted on only in the idle state, and it moves the block to busy (`busy_o`=1). A pair on `in_valid_i` is inserted only while busy. Pairs presented while idle, and pairs presented in the start cycle itself, leave the slots unchanged.
- R3: After each accepted pair, slot j (the field at bits [j*MAG_W +: MAG_W] of `rank_mag_o`) holds the (j+1)-th largest magnitude among all values accepted since the last clear, padded with zero-magnitude slots. Slot 0 is the maximum.
- R4: Each slot's index (bits [j*IDX_W +: IDX_W] of `rank_idx_o`) is the index that came in with that slot's magnitude.
- R5: On equal magnitudes, the bank-0 value ranks above the bank-1 value of the same pair, and an entry already stored ranks above a newly arriving one.
- R6: A value whose magnitude does not exceed the magnitude in the last slot is dropped, and the stored entries are unchanged by it.
- R7: In the clock edge that accepts the `NUM_PAIRS`-th pair, `busy_o` falls and `done_o` rises. `done_o` is high for exactly one cycle.
- R8: After done, the slots stay stable, and further `start_i` or `in_valid_i` pulses are ignored until a clear.
- R9: A start pulse that arrives while busy does not restart the pair count.
- R10: A clear that coincides with the final pair wins: the buffer empties and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Empty the ranked buffer before a new symbol |
| start_i | input | 1 | Metric stage has finished; arm the sorter |
| in_valid_i | input | 1 | A pair of magnitudes is present |
| mag0_i | input | MAG_W | Magnitude from bank 0 |
| idx0_i | input | IDX_W | Pattern/shift index of bank-0 value |
| mag1_i | input | MAG_W | Magnitude from bank 1 |
| idx1_i | input | IDX_W | Pattern/shift index of bank-1 value |
| busy_o | output | 1 | Accepting pairs |
| done_o | output | 1 | One-cycle pulse after the last pair |
| rank_mag_o | output | DEPTH*MAG_W | Ranked magnitudes, slot 0 in the low bits |
| rank_idx_o | output | DEPTH*IDX_W | Indices matching each ranked slot |

## Verification
The final insertion and a clear can fall in the same cycle. The bench provokes this by holding `clr_i` high while it presents the last pair. It then requires empty slots and no done pulse, since clear must dominate. Tie handling is stressed in two ways:
- A narrow magnitude width with random values, so that equal magnitudes are frequent.
- A symbol made only of equal values.

After every step, each slot's magnitude and index are compared with an insertion model that the bench computes itself.

// File: rtl/topk_pkg.sv
package topk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } sort_state_e;
endpackage

// File: rtl/topk_pair_order.sv
module topk_pair_order #(
  parameter int MAG_W = 16,
  parameter int IDX_W = 6
) (
  input  logic [MAG_W-1:0] mag0_i,
  input  logic [IDX_W-1:0] idx0_i,
  input  logic [MAG_W-1:0] mag1_i,
  input  logic [IDX_W-1:0] idx1_i,
  output logic [MAG_W-1:0] hi_mag_o,
  output logic [IDX_W-1:0] hi_idx_o,
  output logic [MAG_W-1:0] lo_mag_o,
  output logic [IDX_W-1:0] lo_idx_o
);
  logic b0_first;

  // bank 0 wins a tie (R5)
  assign b0_first = (mag0_i >= mag1_i);

  always_comb begin
    if (b0_first) begin
      hi_mag_o = mag0_i;  hi_idx_o = idx0_i;
      lo_mag_o = mag1_i;  lo_idx_o = idx1_i;
    end else begin
      hi_mag_o = mag1_i;  hi_idx_o = idx1_i;
      lo_mag_o = mag0_i;  lo_idx_o = idx0_i;
    end
  end

  always_comb begin
    a_r5_pair_order: assert (hi_mag_o >= lo_mag_o);
  end
endmodule

// File: rtl/topk_merge.sv
module topk_merge #(
  parameter int DEPTH = 7,
  parameter int MAG_W = 16,
  parameter int IDX_W = 6
) (
  input  logic [MAG_W-1:0] cur_mag_i [DEPTH],
  input  logic [IDX_W-1:0] cur_idx_i [DEPTH],
  input  logic [MAG_W-1:0] hi_mag_i,
  input  logic [IDX_W-1:0] hi_idx_i,
  input  logic [MAG_W-1:0] lo_mag_i,
  input  logic [IDX_W-1:0] lo_idx_i,
  output logic [MAG_W-1:0] nxt_mag_o [DEPTH],
  output logic [IDX_W-1:0] nxt_idx_o [DEPTH]
);
  // thermometer flags: stored entry i stays above the new value (ties keep stored, R5)
  logic [DEPTH-1:0] above_hi;
  logic [DEPTH-1:0] above_lo;
  int unsigned      pos_hi;
  int unsigned      pos_lo;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign above_hi[g] = (cur_mag_i[g] >= hi_mag_i);
    assign above_lo[g] = (cur_mag_i[g] >= lo_mag_i);
  end

  always_comb begin
    pos_hi = 0;
    pos_lo = 0;
    for (int i = 0; i < DEPTH; i++) begin
      pos_hi = pos_hi + {31'd0, above_hi[i]};
      pos_lo = pos_lo + {31'd0, above_lo[i]};
    end
    pos_lo = pos_lo + 1;  // the low value also sits under the high one
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    localparam int S1 = (j > 0) ? j - 1 : 0;
    localparam int S2 = (j > 1) ? j - 2 : 0;
    always_comb begin
      if (j < pos_hi) begin
        nxt_mag_o[j] = cur_mag_i[j];   nxt_idx_o[j] = cur_idx_i[j];
      end else if (j == pos_hi) begin
        nxt_mag_o[j] = hi_mag_i;       nxt_idx_o[j] = hi_idx_i;
      end else if (j < pos_lo) begin
        nxt_mag_o[j] = cur_mag_i[S1];  nxt_idx_o[j] = cur_idx_i[S1];
      end else if (j == pos_lo) begin
        nxt_mag_o[j] = lo_mag_i;       nxt_idx_o[j] = lo_idx_i;
      end else begin
        nxt_mag_o[j] = cur_mag_i[S2];  nxt_idx_o[j] = cur_idx_i[S2];
      end
    end
  end
endmodule

// File: rtl/topk_ctrl.sv
module topk_ctrl
  import topk_pkg::*;
#(
  parameter int NUM_PAIRS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic start_i,
  input  logic in_valid_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(NUM_PAIRS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_PAIRS - 1);

  sort_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  assign busy_o   = (st_q == ST_RUN);
  assign accept_o = busy_o & in_valid_i & ~clr_i;
  assign done_o   = done_q;
  assign cnt_en   = clr_i | accept_o | (st_q == ST_IDLE && start_i);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (clr_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end
        ST_RUN: if (in_valid_i) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            st_d   = ST_HOLD;
            done_d = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o));
  a_r10_clear_blocks_done: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !done_o && !busy_o);
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> cnt_q <= LAST);
endmodule

// File: rtl/corr_topk_sorter.sv
module corr_topk_sorter #(
  parameter int MAG_W     = 16,
  parameter int IDX_W     = 6,
  parameter int DEPTH     = 7,
  parameter int NUM_PAIRS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   start_i,
  input  logic                   in_valid_i,
  input  logic [MAG_W-1:0]       mag0_i,
  input  logic [IDX_W-1:0]       idx0_i,
  input  logic [MAG_W-1:0]       mag1_i,
  input  logic [IDX_W-1:0]       idx1_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [DEPTH*MAG_W-1:0] rank_mag_o,
  output logic [DEPTH*IDX_W-1:0] rank_idx_o
);
  logic [MAG_W-1:0] mag_q [DEPTH];
  logic [IDX_W-1:0] idx_q [DEPTH];
  logic [MAG_W-1:0] mag_m [DEPTH];
  logic [IDX_W-1:0] idx_m [DEPTH];
  logic [MAG_W-1:0] hi_mag, lo_mag;
  logic [IDX_W-1:0] hi_idx, lo_idx;
  logic             accept;
  logic             slot_en;

  topk_ctrl #(.NUM_PAIRS(NUM_PAIRS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .start_i(start_i),
    .in_valid_i(in_valid_i), .accept_o(accept), .busy_o(busy_o), .done_o(done_o)
  );

  topk_pair_order #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_order (
    .mag0_i(mag0_i), .idx0_i(idx0_i), .mag1_i(mag1_i), .idx1_i(idx1_i),
    .hi_mag_o(hi_mag), .hi_idx_o(hi_idx), .lo_mag_o(lo_mag), .lo_idx_o(lo_idx)
  );

  topk_merge #(.DEPTH(DEPTH), .MAG_W(MAG_W), .IDX_W(IDX_W)) u_merge (
    .cur_mag_i(mag_q), .cur_idx_i(idx_q),
    .hi_mag_i(hi_mag), .hi_idx_i(hi_idx), .lo_mag_i(lo_mag), .lo_idx_i(lo_idx),
    .nxt_mag_o(mag_m), .nxt_idx_o(idx_m)
  );

  assign slot_en = clr_i | accept;

  for (genvar j = 0; j < DEPTH; j++) begin : g_reg
    logic [MAG_W-1:0] mag_d;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
      mag_d = clr_i ? '0 : mag_m[j];
      idx_d = clr_i ? '0 : idx_m[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mag_q[j] <= '0;
        idx_q[j] <= '0;
      end else if (slot_en) begin
        mag_q[j] <= mag_d;
        idx_q[j] <= idx_d;
      end
    end

    assign rank_mag_o[j*MAG_W +: MAG_W] = mag_q[j];
    assign rank_idx_o[j*IDX_W +: IDX_W] = idx_q[j];

    if (j > 0) begin : g_ord
      a_r3_descending: assert property (@(posedge clk) disable iff (!rst_n)
        mag_q[j-1] >= mag_q[j]);
    end
  end

  a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> rank_mag_o == '0 && rank_idx_o == '0);
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !clr_i) |=> $stable(rank_mag_o) && $stable(rank_idx_o));
  a_r3_top_is_max: assert property (@(posedge clk) disable iff (!rst_n)
    (accept) |=> mag_q[0] >= $past(mag0_i) && mag_q[0] >= $past(mag1_i));
  a_r6_last_not_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (accept) |=> mag_q[DEPTH-1] >= $past(mag_q[DEPTH-1]));
endmodule

// File: tb/corr_topk_sorter_bench.sv
module corr_topk_sorter_bench;
  localparam int MW = 4;
  localparam int IW = 5;
  localparam int D  = 7;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic clr_i, start_i, in_valid_i;
  logic [MW-1:0] mag0_i, mag1_i;
  logic [IW-1:0] idx0_i, idx1_i;
  logic busy_o, done_o;
  logic [D*MW-1:0] rank_mag_o;
  logic [D*IW-1:0] rank_idx_o;

  int n_chk = 0;
  int n_bad = 0;
  int ref_m [D];
  int ref_i [D];
  logic [15:0] rng = 16'hACE1;
  bit finished = 0;

  always #10 clk = ~clk;

  corr_topk_sorter #(.MAG_W(MW), .IDX_W(IW), .DEPTH(D), .NUM_PAIRS(NP)) u_corr_topk_sorter (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .start_i(start_i), .in_valid_i(in_valid_i),
    .mag0_i(mag0_i), .idx0_i(idx0_i), .mag1_i(mag1_i), .idx1_i(idx1_i),
    .busy_o(busy_o), .done_o(done_o), .rank_mag_o(rank_mag_o), .rank_idx_o(rank_idx_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nxt_rand();
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
    return int'(rng[MW-1:0]);
  endfunction

  // model: strictly larger value displaces; equal stays below (R5, R6)
  function automatic void model_put(input int m, input int ix);
    for (int p = 0; p < D; p++) begin
      if (m > ref_m[p]) begin
        for (int q = D - 1; q > p; q--) begin
          ref_m[q] = ref_m[q-1];
          ref_i[q] = ref_i[q-1];
        end
        ref_m[p] = m;
        ref_i[p] = ix;
        return;
      end
    end
  endfunction

  function automatic void model_clear();
    for (int p = 0; p < D; p++) begin ref_m[p] = 0; ref_i[p] = 0; end
  endfunction

  task automatic chk_slots(input string req);
    for (int j = 0; j < D; j++) begin
      chk({req, " mag"}, int'(rank_mag_o[j*MW +: MW]), ref_m[j]);
      chk({req, " idx"}, int'(rank_idx_o[j*IW +: IW]), ref_i[j]);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_clear();
    clr_i = 1'b1; tick(); clr_i = 1'b0;
    model_clear();
  endtask

  task automatic do_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic put_pair(input int m0, input int i0, input int m1, input int i1);
    mag0_i = MW'(m0); idx0_i = IW'(i0); mag1_i = MW'(m1); idx1_i = IW'(i1);
    in_valid_i = 1'b1; tick(); in_valid_i = 1'b0;
    model_put(m0, i0);
    model_put(m1, i1);
  endtask

  // one symbol: the mode picks the value pattern
  task automatic run_symbol(input int mode);
    int m0, m1;
    do_clear();
    chk_slots("R1_clear");
    do_start();
    chk("R2_busy", int'(busy_o), 1);
    for (int s = 0; s < NP; s++) begin
      case (mode)
        0: begin m0 = nxt_rand(); m1 = nxt_rand(); end
        1: begin m0 = 9; m1 = 9; end
        2: begin m0 = 15 - 2*s; m1 = 14 - 2*s; end
        default: begin m0 = 2*s; m1 = 2*s + 1; end
      endcase
      put_pair(m0, 2*s, m1, 2*s + 1);
      chk_slots(mode == 1 ? "R5_tie" : "R3_R4_rank");
      if (s == NP - 1) begin
        chk("R7_done", int'(done_o), 1);
        chk("R7_busy_fall", int'(busy_o), 0);
      end else begin
        chk("R7_no_early_done", int'(done_o), 0);
      end
    end
    tick();
    chk("R7_done_pulse", int'(done_o), 0);
    // R8: extra traffic after done is ignored
    start_i = 1'b1; mag0_i = '1; mag1_i = '1; idx0_i = 5'd30; idx1_i = 5'd31;
    in_valid_i = 1'b1; tick(); tick();
    start_i = 1'b0; in_valid_i = 1'b0; tick();
    chk_slots("R8_hold");
    chk("R8_no_busy", int'(busy_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; clr_i = 0; start_i = 0; in_valid_i = 0;
    mag0_i = '0; mag1_i = '0; idx0_i = '0; idx1_i = '0;
    model_clear();
    repeat (3) tick();
    chk("R1_reset_busy", int'(busy_o), 0);
    chk("R1_reset_done", int'(done_o), 0);
    chk_slots("R1_reset");
    rst_n = 1'b1;
    tick();

    // R2: valid while idle and in the start cycle is ignored
    do_clear();
    mag0_i = 4'd12; mag1_i = 4'd11; idx0_i = 5'd3; idx1_i = 5'd4;
    in_valid_i = 1'b1; tick();
    chk_slots("R2_idle_ignored");
    start_i = 1'b1; tick(); start_i = 1'b0; in_valid_i = 1'b0;
    chk_slots("R2_start_cycle_ignored");
    // R9: start while busy does not restart the count
    for (int s = 0; s < NP - 1; s++) begin
      if (s == 2) start_i = 1'b1;
      put_pair(s + 1, 2*s, s + 2, 2*s + 1);
      start_i = 1'b0;
    end
    put_pair(7, 20, 3, 21);
    chk("R9_done_on_count", int'(done_o), 1);
    chk_slots("R9_rank");

    // R10: clear in the cycle of the final pair
    do_clear();
    do_start();
    for (int s = 0; s < NP - 1; s++) put_pair(5, 2*s, 6, 2*s + 1);
    clr_i = 1'b1; mag0_i = 4'd15; mag1_i = 4'd15; in_valid_i = 1'b1; tick();
    clr_i = 1'b0; in_valid_i = 1'b0;
    model_clear();
    chk_slots("R10_clear_wins");
    chk("R10_no_done", int'(done_o), 0);
    tick();
    chk("R10_no_done_later", int'(done_o), 0);

    // near-exhaustive sweep over patterns
    run_symbol(1);
    run_symbol(2);
    run_symbol(3);
    for (int k = 0; k < 60; k++) run_symbol(0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule